// File: doc/BRIEF.md
# Supply Supervisor Reset Timer

This block turns an undervoltage flag from an analog supply comparator into a clean system reset. The flag is asynchronous to the block's clock. It passes through a synchronizer and then a glitch filter, so a supply dip shorter than a set number of cycles is ignored. A dip that lasts long enough puts the block into reset. Reset stays asserted for as long as the supply is low. After the supply recovers, reset is held for a long recovery timeout before it is released.

A static strap selects whether the reset output is active high or active low. A separate ready output is high only while the block is out of reset, whatever the strap says. The filter length, the hold timeout and the synchronizer depth are parameters counted in clock cycles. The defaults are about 4 us of filtering and about 240 ms of hold at 200 MHz. When the block's own logic is reset, it comes up in reset and then runs a full hold.

Top module: `svr_reset_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released with the flag low, reset stays asserted (`ready`=0) until `HOLD_CYC+SYNC_STAGES+1` clock edges after the release, and is deasserted at that edge.
- R2: When `uv_flag` rises and stays high, `ready` falls exactly at the `FILT_CYC+SYNC_STAGES+1`-th clock edge after the rise.
- R3: An undervoltage pulse that lasts `FILT_CYC-1` clock cycles has no effect on `ready` or `sys_rst`.
- R4: Reset stays asserted for as long as `uv_flag` remains high.
- R5: After `uv_flag` falls, reset is deasserted (`ready` rises) exactly at the `HOLD_CYC+SYNC_STAGES+1`-th clock edge.
- R6: A dip of `FILT_CYC` or more cycles during the recovery hold restarts the hold. Release then comes `HOLD_CYC+SYNC_STAGES+1` edges after the end of that dip.
- R7: A dip shorter than `FILT_CYC` cycles during the recovery hold neither restarts nor extends the hold.
- R8: With `pol_high`=1, `sys_rst` is 1 while in reset and 0 otherwise. With `pol_high`=0, it is the inverse. `ready` does not depend on the strap.
- R9: The glitch filter counts only consecutive undervoltage samples. Two pulses of `FILT_CYC-1` cycles, separated by one good cycle, cause no reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset of the block's own logic |
| uv_flag | input | 1 | Asynchronous comparator flag, 1 = supply below threshold |
| pol_high | input | 1 | Polarity strap, 1 = active-high reset output |
| sys_rst | output | 1 | System reset output with strap-selected polarity |
| ready | output | 1 | 1 when the block is out of reset |

## Verification
The bench builds the block with `FILT_CYC`=6, `HOLD_CYC`=40 and a two-stage synchronizer. With these values, every edge of every window can be hit within a few hundred cycles. This puts the exact assert and release edges within reach, as well as the boundary where a pulse one cycle shorter than the filter is ignored. It also puts dips inside the hold, both long and short, within reach, so that a restarted hold can be told apart from one that runs to its end undisturbed.

// File: rtl/svr_pkg.sv
package svr_pkg;
    typedef enum logic [1:0] {
        PH_DOWN = 2'd0,
        PH_HOLD = 2'd1,
        PH_RUN  = 2'd2
    } svr_phase_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/svr_sync.sv
module svr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sh: {STAGES{1'b1}}};
        else        st_q <= st_d;
    end

    assign dout = st_q.sh[STAGES-1];

    initial begin
        AST_SYNC_DEPTH : assert (STAGES >= 2); // R2
    end
endmodule

// File: rtl/svr_glitch_filter.sv
module svr_glitch_filter
    import svr_pkg::*;
#(
    parameter int unsigned FILT_CYC = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_s,
    output logic low_o
);
    localparam int unsigned FCW = cnt_width(FILT_CYC);
    localparam logic [FCW-1:0] FLAST = FCW'(FILT_CYC - 1);

    typedef struct packed {
        logic [FCW-1:0] cnt;
        logic           low;
    } filt_s;

    filt_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!uv_s) begin
            st_d.cnt = '0;
            st_d.low = 1'b0;
        end else if (!st_q.low) begin
            if (st_q.cnt == FLAST) begin
                st_d.cnt = '0;
                st_d.low = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, low: 1'b1};
        else        st_q <= st_d;
    end

    assign low_o = st_q.low;

    AST_LOW_NEEDS_UV : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.low) |-> $past(uv_s)); // R2
    AST_GOOD_CLEARS : assert property (@(posedge clk) disable iff (!rst_n)
        !uv_s |=> (!st_q.low && st_q.cnt == '0)); // R9
endmodule

// File: rtl/svr_hold_timer.sv
module svr_hold_timer
    import svr_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 48_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_i,
    output logic rst_o
);
    localparam int unsigned HCW = cnt_width(HOLD_CYC);
    localparam logic [HCW-1:0] HLAST = HCW'(HOLD_CYC - 1);

    typedef struct packed {
        svr_phase_e     ph;
        logic [HCW-1:0] cnt;
    } hold_s;

    hold_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (low_i) begin
            st_d.ph  = PH_DOWN;
            st_d.cnt = '0;
        end else begin
            unique case (st_q.ph)
                PH_DOWN, PH_HOLD: begin
                    if (st_q.cnt == HLAST) begin
                        st_d.ph  = PH_RUN;
                        st_d.cnt = '0;
                    end else begin
                        st_d.ph  = PH_HOLD;
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: begin
                    st_d.ph  = PH_RUN;
                    st_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_DOWN, cnt: '0};
        else        st_q <= st_d;
    end

    assign rst_o = (st_q.ph != PH_RUN);

    AST_RST_WHILE_LOW : assert property (@(posedge clk) disable iff (!rst_n)
        low_i |=> rst_o); // R4
    AST_RELEASE_CLEAN : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_o) |-> $past(!low_i)); // R5
    AST_NO_OVERFLOW : assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.cnt) < HOLD_CYC); // R5
endmodule

// File: rtl/svr_reset_timer.sv
module svr_reset_timer #(
    parameter int unsigned FILT_CYC    = 800,
    parameter int unsigned HOLD_CYC    = 48_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_flag,
    input  logic pol_high,
    output logic sys_rst,
    output logic ready
);
    logic uv_s;
    logic low_w;
    logic in_rst;

    svr_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (uv_flag),
        .dout (uv_s)
    );

    svr_glitch_filter #(.FILT_CYC(FILT_CYC)) filt_i (
        .clk  (clk),
        .rst_n(rst_n),
        .uv_s (uv_s),
        .low_o(low_w)
    );

    svr_hold_timer #(.HOLD_CYC(HOLD_CYC)) hold_i (
        .clk  (clk),
        .rst_n(rst_n),
        .low_i(low_w),
        .rst_o(in_rst)
    );

    assign sys_rst = pol_high ? in_rst : ~in_rst;
    assign ready   = ~in_rst;

    AST_POL_LEVEL : assert property (@(posedge clk) disable iff (!rst_n)
        (!ready) |-> (sys_rst == pol_high)); // R8
endmodule

// File: tb/svr_reset_timer_tb.sv
module svr_reset_timer_tb_top;
    localparam int unsigned FILT = 6;
    localparam int unsigned HOLD = 40;
    localparam int unsigned SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv_flag = 1'b0;
    logic pol_high = 1'b1;
    logic sys_rst, ready;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    svr_reset_timer #(.FILT_CYC(FILT), .HOLD_CYC(HOLD), .SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .pol_high(pol_high),
        .sys_rst(sys_rst), .ready(ready)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_logic_reset();
        uv_flag = 1'b0;
        rst_n = 1'b0;
        tick(3);
        check("R1 ready in reset", ready, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        tick(HOLD + SYNC);
        check("R1 still held", ready, 1'b0);
        tick(1);
        check("R1 released", ready, 1'b1);
    endtask

    task automatic t_polarity();
        pol_high = 1'b1; #1;
        check("R8 high pol idle", sys_rst, 1'b0);
        pol_high = 1'b0; #1;
        check("R8 low pol idle", sys_rst, 1'b1);
        @(negedge clk); uv_flag = 1'b1;
        tick(FILT + SYNC + 2);
        check("R8 low pol asserted", sys_rst, 1'b0);
        check("R8 ready low pol", ready, 1'b0);
        pol_high = 1'b1; #1;
        check("R8 high pol asserted", sys_rst, 1'b1);
        check("R8 ready high pol", ready, 1'b0);
        @(negedge clk); uv_flag = 1'b0;
        tick(HOLD + SYNC + 2);
    endtask

    task automatic t_assert_release();
        @(negedge clk); uv_flag = 1'b1;
        tick(FILT + SYNC);
        check("R2 not yet", ready, 1'b1);
        tick(1);
        check("R2 asserted", ready, 1'b0);
        tick(60);
        check("R4 held while low", ready, 1'b0);
        @(negedge clk); uv_flag = 1'b0;
        tick(HOLD + SYNC);
        check("R5 still held", ready, 1'b0);
        tick(1);
        check("R5 released", ready, 1'b1);
    endtask

    task automatic t_glitch();
        int drops = 0;
        @(negedge clk); uv_flag = 1'b1;
        repeat (FILT - 1) @(negedge clk);
        uv_flag = 1'b0;
        repeat (FILT + SYNC + 10) begin
            tick(1);
            if (ready !== 1'b1 || sys_rst !== 1'b0) drops++;
        end
        check("R3 short pulse ignored", drops == 0, 1'b1);
    endtask

    task automatic t_split();
        int drops = 0;
        @(negedge clk); uv_flag = 1'b1;
        repeat (FILT - 1) @(negedge clk);
        uv_flag = 1'b0;
        @(negedge clk); uv_flag = 1'b1;
        repeat (FILT - 1) @(negedge clk);
        uv_flag = 1'b0;
        repeat (FILT + SYNC + 10) begin
            tick(1);
            if (ready !== 1'b1) drops++;
        end
        check("R9 split pulses ignored", drops == 0, 1'b1);
    endtask

    task automatic t_restart();
        @(negedge clk); uv_flag = 1'b1;
        tick(FILT + SYNC + 4);
        @(negedge clk); uv_flag = 1'b0;
        repeat (HOLD / 2) @(negedge clk);
        uv_flag = 1'b1;
        repeat (FILT + 2) @(negedge clk);
        uv_flag = 1'b0;
        tick(HOLD + SYNC);
        check("R6 restarted hold", ready, 1'b0);
        tick(1);
        check("R6 release after restart", ready, 1'b1);
    endtask

    task automatic t_short_in_hold();
        int rem;
        @(negedge clk); uv_flag = 1'b1;
        tick(FILT + SYNC + 4);
        @(negedge clk); uv_flag = 1'b0;
        repeat (10) @(negedge clk);
        uv_flag = 1'b1;
        repeat (FILT - 1) @(negedge clk);
        uv_flag = 1'b0;
        rem = HOLD + SYNC + 1 - 10 - (FILT - 1);
        tick(rem - 1);
        check("R7 hold not finished", ready, 1'b0);
        tick(1);
        check("R7 hold not extended", ready, 1'b1);
    endtask

    initial begin
        t_logic_reset();
        t_polarity();
        t_assert_release();
        t_glitch();
        t_split();
        t_restart();
        t_short_in_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule